// File: doc/BRIEF.md
# Windowed Integer Register File with Window Traps

This block is the integer register file of a load-store processor that uses overlapping register windows. Software sees 32 register numbers. The block maps them onto a larger physical array through a current window pointer. Register numbers 0 to 7 are globals that every window shares. Numbers 8 to 15 are the outs, 16 to 23 the locals and 24 to 31 the ins. Neighbouring windows share storage: the outs of one window are the ins of the window one below it. A caller can therefore place arguments and a return address in its outs, and the callee finds them in its ins once it has moved to a new window.

A save request moves the pointer down by one window and a restore request moves it up by one, both modulo the window count. An invalid-window mask holds one bit per window. If a save or restore would land on a window marked invalid, the pointer is held and a one-cycle overflow or underflow pulse is raised for the trap logic outside this block. A small state machine produces those pulses. Its states are WIN_RUN (no trap), WIN_OVF (overflow pulse) and WIN_UNF (underflow pulse). Each cycle, a blocked save moves it to WIN_OVF, a blocked restore moves it to WIN_UNF, and anything else moves it to WIN_RUN. So each trap state lasts one cycle unless the next request is also blocked. Software can load the pointer and the mask directly. A call-link input writes a return address into out register 7.

Top module: `winreg_file`

## Requirements
- R1: Register numbers 1 to 7 are globals: a value written through any window reads back the same through every window.
- R2: Register number 0 reads as zero on both read ports, and writes to it are discarded.
- R3: Register numbers 16 to 23 are locals, private to each window: a value written to a local in window w is read back only in window w.
- R4: Register number 8+k (k = 0..7) in window w is the same storage as register number 24+k in window (w-1) mod NWIN. Reads are combinational from the current pointer.
- R5: A save whose target window (cwp-1) mod NWIN has its mask bit clear sets the pointer to that target at the next clock edge. The pointer wraps from 0 to NWIN-1.
- R6: A restore whose target window (cwp+1) mod NWIN has its mask bit clear sets the pointer to that target at the next clock edge. The pointer wraps from NWIN-1 to 0.
- R7: A save whose target window has its mask bit set (bit i stands for window i, 1 = invalid) leaves the pointer unchanged. Overflow is then high for exactly the one cycle after the request.
- R8: A restore whose target window has its mask bit set leaves the pointer unchanged. Underflow is then high for exactly the one cycle after the request.
- R9: A call-link write stores link_data into register 15 of the current window. In the same cycle it takes priority over the ordinary write port. After a save, the value reads as register 31.
- R10: A software write loads the pointer and the mask at the next edge. It overrides any save or restore in the same cycle, and that save or restore raises no trap.
- R11: When save and restore are requested together, only the save is acted on.
- R12: After reset the pointer is 0, the mask has only bit 1 set, and both trap flags are low.
- R13: Overflow and underflow are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_addr | input | 5 | Read port A register number |
| rd_a_data | output | XLEN | Read port A data |
| rd_b_addr | input | 5 | Read port B register number |
| rd_b_data | output | XLEN | Read port B data |
| wr_en | input | 1 | Write port enable |
| wr_addr | input | 5 | Write port register number |
| wr_data | input | XLEN | Write port data |
| link_en | input | 1 | Call-link write of register 15 |
| link_data | input | XLEN | Return address to store |
| save_req | input | 1 | Move to the next lower window |
| restore_req | input | 1 | Move to the next higher window |
| sw_wr_en | input | 1 | Load pointer and mask from software |
| sw_cwp | input | $clog2(NWIN) | Pointer value to load |
| sw_mask | input | NWIN | Mask value to load |
| cwp | output | $clog2(NWIN) | Current window pointer |
| win_mask | output | NWIN | Invalid-window mask |
| overflow | output | 1 | One-cycle save trap pulse |
| underflow | output | 1 | One-cycle restore trap pulse |

## Verification
The overlap between windows is the hardest thing to observe from the ports. A value written through one window has to be found again in a different window and under a different register number. The bench uses the software pointer load to reach each window directly and writes a tag into every local and in. The tag encodes both the window and the register. The bench then sweeps all windows and works out the expected tag for every out and local by arithmetic. Trap cases use mask values that place the single invalid bit just below or just above the pointer, and some of those cases also exercise the wrap-around.

// File: rtl/winreg_pkg.sv
package winreg_pkg;
    typedef enum logic [1:0] {
        WIN_RUN = 2'd0,
        WIN_OVF = 2'd1,
        WIN_UNF = 2'd2
    } win_state_e;

    localparam int GLOBALS  = 8;
    localparam int PER_WIN  = 16;
    localparam int LINK_REG = 15;
endpackage

// File: rtl/winreg_map.sv
module winreg_map #(
    parameter int NWIN = 8,
    parameter int PW   = 3,
    parameter int IW   = 8
) (
    input  logic [4:0]    arch,
    input  logic [PW-1:0] cwp,
    output logic [IW-1:0] idx
);
    import winreg_pkg::*;

    logic [PW-1:0] below;
    assign below = cwp - PW'(1);

    always_comb begin
        unique case (arch[4:3])
            2'd0: idx = IW'(int'(arch[2:0]));
            2'd1: idx = IW'(GLOBALS + PER_WIN * int'(below) + 8 + int'(arch[2:0]));
            2'd2: idx = IW'(GLOBALS + PER_WIN * int'(cwp) + int'(arch[2:0]));
            default: idx = IW'(GLOBALS + PER_WIN * int'(cwp) + 8 + int'(arch[2:0]));
        endcase
    end
endmodule

// File: rtl/winreg_array.sv
module winreg_array #(
    parameter int XLEN  = 32,
    parameter int NPHYS = 136,
    parameter int IW    = 8
) (
    input  logic            clk,
    input  logic            we,
    input  logic [IW-1:0]   widx,
    input  logic [XLEN-1:0] wdata,
    input  logic [IW-1:0]   ra_idx,
    input  logic [IW-1:0]   rb_idx,
    output logic [XLEN-1:0] ra_data,
    output logic [XLEN-1:0] rb_data
);
    logic [XLEN-1:0] mem [NPHYS];

    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wdata;
    end

    assign ra_data = mem[ra_idx];
    assign rb_data = mem[rb_idx];
endmodule

// File: rtl/winreg_ctrl.sv
module winreg_ctrl #(
    parameter int NWIN = 8,
    parameter int PW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            save_req,
    input  logic            restore_req,
    input  logic            sw_wr_en,
    input  logic [PW-1:0]   sw_cwp,
    input  logic [NWIN-1:0] sw_mask,
    output logic [PW-1:0]   cwp,
    output logic [NWIN-1:0] win_mask,
    output logic            overflow,
    output logic            underflow
);
    import winreg_pkg::*;

    localparam logic [NWIN-1:0] MASK_RST = NWIN'(2);

    win_state_e      state_q, state_d;
    logic [PW-1:0]   cwp_q, cwp_d, dn, up;
    logic [NWIN-1:0] mask_q, mask_d;

    assign dn = cwp_q - PW'(1);
    assign up = cwp_q + PW'(1);

    always_comb begin
        state_d = WIN_RUN;
        cwp_d   = cwp_q;
        mask_d  = mask_q;
        if (sw_wr_en) begin
            cwp_d  = sw_cwp;
            mask_d = sw_mask;
        end else if (save_req) begin
            if (mask_q[dn]) state_d = WIN_OVF;
            else            cwp_d   = dn;
        end else if (restore_req) begin
            if (mask_q[up]) state_d = WIN_UNF;
            else            cwp_d   = up;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WIN_RUN;
            cwp_q   <= '0;
            mask_q  <= MASK_RST;
        end else begin
            state_q <= state_d;
            cwp_q   <= cwp_d;
            mask_q  <= mask_d;
        end
    end

    always_comb begin
        overflow  = 1'b0;
        underflow = 1'b0;
        unique case (state_q)
            WIN_OVF: overflow  = 1'b1;
            WIN_UNF: underflow = 1'b1;
            default: ;
        endcase
    end

    assign cwp      = cwp_q;
    assign win_mask = mask_q;

    // R5
    save_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && !sw_wr_en && !win_mask[PW'(cwp - PW'(1))]) |=> (cwp == PW'($past(cwp) - PW'(1))));
    // R6
    restore_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_req && !save_req && !sw_wr_en && !win_mask[PW'(cwp + PW'(1))]) |=> (cwp == PW'($past(cwp) + PW'(1))));
    // R7
    overflow_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && !sw_wr_en && win_mask[PW'(cwp - PW'(1))]) |=> (overflow && $stable(cwp)));
    // R8
    underflow_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_req && !save_req && !sw_wr_en && win_mask[PW'(cwp + PW'(1))]) |=> (underflow && $stable(cwp)));
    // R10
    sw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_en |=> (!overflow && !underflow && cwp == $past(sw_cwp) && win_mask == $past(sw_mask)));
    // R13
    trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({overflow, underflow}));
endmodule

// File: rtl/winreg_file.sv
module winreg_file #(
    parameter int XLEN = 32,
    parameter int NWIN = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [4:0]               rd_a_addr,
    output logic [XLEN-1:0]          rd_a_data,
    input  logic [4:0]               rd_b_addr,
    output logic [XLEN-1:0]          rd_b_data,
    input  logic                     wr_en,
    input  logic [4:0]               wr_addr,
    input  logic [XLEN-1:0]          wr_data,
    input  logic                     link_en,
    input  logic [XLEN-1:0]          link_data,
    input  logic                     save_req,
    input  logic                     restore_req,
    input  logic                     sw_wr_en,
    input  logic [$clog2(NWIN)-1:0]  sw_cwp,
    input  logic [NWIN-1:0]          sw_mask,
    output logic [$clog2(NWIN)-1:0]  cwp,
    output logic [NWIN-1:0]          win_mask,
    output logic                     overflow,
    output logic                     underflow
);
    import winreg_pkg::*;

    localparam int PW    = $clog2(NWIN);
    localparam int NPHYS = GLOBALS + PER_WIN * NWIN;
    localparam int IW    = $clog2(NPHYS);

    logic [4:0]      w_arch;
    logic [XLEN-1:0] w_data;
    logic            w_en;
    logic [IW-1:0]   w_idx, ra_idx, rb_idx;
    logic [XLEN-1:0] ra_raw, rb_raw;

    assign w_arch = link_en ? 5'(LINK_REG) : wr_addr;
    assign w_data = link_en ? link_data : wr_data;
    assign w_en   = link_en | (wr_en && (wr_addr != 5'd0));

    winreg_ctrl #(.NWIN(NWIN), .PW(PW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .save_req(save_req), .restore_req(restore_req),
        .sw_wr_en(sw_wr_en), .sw_cwp(sw_cwp), .sw_mask(sw_mask),
        .cwp(cwp), .win_mask(win_mask),
        .overflow(overflow), .underflow(underflow)
    );

    winreg_map #(.NWIN(NWIN), .PW(PW), .IW(IW)) u_map_w  (.arch(w_arch),    .cwp(cwp), .idx(w_idx));
    winreg_map #(.NWIN(NWIN), .PW(PW), .IW(IW)) u_map_ra (.arch(rd_a_addr), .cwp(cwp), .idx(ra_idx));
    winreg_map #(.NWIN(NWIN), .PW(PW), .IW(IW)) u_map_rb (.arch(rd_b_addr), .cwp(cwp), .idx(rb_idx));

    winreg_array #(.XLEN(XLEN), .NPHYS(NPHYS), .IW(IW)) u_array (
        .clk(clk), .we(w_en), .widx(w_idx), .wdata(w_data),
        .ra_idx(ra_idx), .rb_idx(rb_idx),
        .ra_data(ra_raw), .rb_data(rb_raw)
    );

    assign rd_a_data = (rd_a_addr == 5'd0) ? '0 : ra_raw;
    assign rd_b_data = (rd_b_addr == 5'd0) ? '0 : rb_raw;

    // R2
    zero_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        w_en |-> (w_idx != '0));
    // R9
    link_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_en |-> (w_arch == 5'd15 && w_data == link_data));
endmodule

// File: tb/test_winreg_file.sv
`timescale 1ns/1ps
module test_winreg_file;
    localparam int XLEN = 32;
    localparam int NWIN = 8;
    localparam int PW   = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [4:0]      rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
    logic [XLEN-1:0] rd_a_data, rd_b_data, wr_data = '0, link_data = '0;
    logic            wr_en = 1'b0, link_en = 1'b0;
    logic            save_req = 1'b0, restore_req = 1'b0, sw_wr_en = 1'b0;
    logic [PW-1:0]   sw_cwp = '0, cwp;
    logic [NWIN-1:0] sw_mask = '0, win_mask;
    logic            overflow, underflow;

    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    winreg_file #(.XLEN(XLEN), .NWIN(NWIN)) i_winreg_file (
        .clk(clk), .rst_n(rst_n),
        .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
        .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .link_en(link_en), .link_data(link_data),
        .save_req(save_req), .restore_req(restore_req),
        .sw_wr_en(sw_wr_en), .sw_cwp(sw_cwp), .sw_mask(sw_mask),
        .cwp(cwp), .win_mask(win_mask),
        .overflow(overflow), .underflow(underflow)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic sw_load(input logic [PW-1:0] c, input logic [NWIN-1:0] m);
        sw_wr_en = 1'b1; sw_cwp = c; sw_mask = m;
        tick();
        sw_wr_en = 1'b0;
    endtask

    task automatic wreg(input logic [4:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rda(input logic [4:0] a, output logic [31:0] d);
        rd_a_addr = a; #1; d = rd_a_data;
    endtask

    task automatic rdb(input logic [4:0] a, output logic [31:0] d);
        rd_b_addr = a; #1; d = rd_b_data;
    endtask

    function automatic logic [31:0] tag(input int w, input int r);
        return 32'hA500_0000 | 32'(w << 8) | 32'(r);
    endfunction

    initial begin
        #(200000 * 10);
        fails++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) tick();
        rst_n = 1'b1;
        // R12 reset state
        chk("R12 cwp", 32'(cwp), 32'd0);
        chk("R12 mask", 32'(win_mask), 32'h2);
        chk("R12 flags", {30'd0, overflow, underflow}, 32'd0);
        // R8 restore from reset lands on invalid window 1
        restore_req = 1'b1; tick(); restore_req = 1'b0;
        chk("R8 underflow", 32'(underflow), 32'd1);
        chk("R13 no overflow", 32'(overflow), 32'd0);
        chk("R8 cwp held", 32'(cwp), 32'd0);
        tick();
        chk("R8 pulse ends", 32'(underflow), 32'd0);

        // R1 globals
        sw_load(0, '0);
        for (int r = 1; r < 8; r++) wreg(5'(r), tag(99, r));
        for (int w = 0; w < NWIN; w++) begin
            sw_load(PW'(w), '0);
            for (int r = 1; r < 8; r++) begin
                rda(5'(r), v); chk("R1 global", v, tag(99, r));
            end
        end

        // R2 register zero
        wreg(5'd0, 32'hFFFF_FFFF);
        rda(5'd0, v); chk("R2 read A", v, 32'd0);
        rdb(5'd0, v); chk("R2 read B", v, 32'd0);
        rda(5'd1, v); chk("R2 global kept", v, tag(99, 1));

        // R3 / R4 sweep
        for (int w = 0; w < NWIN; w++) begin
            sw_load(PW'(w), '0);
            for (int r = 16; r < 32; r++) wreg(5'(r), tag(w, r));
        end
        for (int w = 0; w < NWIN; w++) begin
            sw_load(PW'(w), '0);
            for (int r = 16; r < 24; r++) begin
                rda(5'(r), v); chk("R3 local", v, tag(w, r));
            end
            for (int r = 24; r < 32; r++) begin
                rdb(5'(r), v); chk("R4 in", v, tag(w, r));
            end
            for (int r = 8; r < 16; r++) begin
                rda(5'(r), v); chk("R4 out", v, tag((w + NWIN - 1) % NWIN, r + 16));
            end
        end

        // R5 save, including wrap
        sw_load(3, '0);
        save_req = 1'b1; tick(); save_req = 1'b0;
        chk("R5 save", 32'(cwp), 32'd2);
        chk("R5 no trap", 32'(overflow), 32'd0);
        sw_load(0, '0);
        save_req = 1'b1; tick(); save_req = 1'b0;
        chk("R5 wrap", 32'(cwp), 32'd7);
        // R6 restore, including wrap
        restore_req = 1'b1; tick(); restore_req = 1'b0;
        chk("R6 wrap", 32'(cwp), 32'd0);
        sw_load(3, '0);
        restore_req = 1'b1; tick(); restore_req = 1'b0;
        chk("R6 restore", 32'(cwp), 32'd4);

        // R7 overflow
        sw_load(3, 8'b0000_0100);
        save_req = 1'b1; tick(); save_req = 1'b0;
        chk("R7 overflow", 32'(overflow), 32'd1);
        chk("R7 cwp held", 32'(cwp), 32'd3);
        chk("R13 no underflow", 32'(underflow), 32'd0);
        tick();
        chk("R7 pulse ends", 32'(overflow), 32'd0);
        sw_load(0, 8'b1000_0000);
        save_req = 1'b1; tick(); save_req = 1'b0;
        chk("R7 overflow wrap", 32'(overflow), 32'd1);
        chk("R7 cwp held wrap", 32'(cwp), 32'd0);
        // R8 underflow
        sw_load(3, 8'b0001_0000);
        restore_req = 1'b1; tick(); restore_req = 1'b0;
        chk("R8 underflow", 32'(underflow), 32'd1);
        chk("R8 cwp held", 32'(cwp), 32'd3);

        // R9 link write with priority and visibility after save
        sw_load(5, '0);
        wr_en = 1'b1; wr_addr = 5'd15; wr_data = 32'h1111_1111;
        link_en = 1'b1; link_data = 32'hC0DE_0040;
        tick();
        wr_en = 1'b0; link_en = 1'b0;
        rda(5'd15, v); chk("R9 link in r15", v, 32'hC0DE_0040);
        save_req = 1'b1; tick(); save_req = 1'b0;
        chk("R9 cwp after save", 32'(cwp), 32'd4);
        rdb(5'd31, v); chk("R9 link in r31", v, 32'hC0DE_0040);

        // R10 software load overrides save
        sw_wr_en = 1'b1; sw_cwp = 3'd6; sw_mask = 8'b0010_0000; save_req = 1'b1;
        tick();
        sw_wr_en = 1'b0; save_req = 1'b0;
        chk("R10 cwp", 32'(cwp), 32'd6);
        chk("R10 mask", 32'(win_mask), 32'h20);
        chk("R10 no trap", {30'd0, overflow, underflow}, 32'd0);
        tick();
        chk("R10 no late trap", {30'd0, overflow, underflow}, 32'd0);

        // R11 save wins over restore
        sw_load(2, '0);
        save_req = 1'b1; restore_req = 1'b1; tick();
        save_req = 1'b0; restore_req = 1'b0;
        chk("R11 save wins", 32'(cwp), 32'd1);
        sw_load(2, 8'b0000_0010);
        save_req = 1'b1; restore_req = 1'b1; tick();
        save_req = 1'b0; restore_req = 1'b0;
        chk("R11 overflow only", {30'd0, overflow, underflow}, 32'd2);
        chk("R11 cwp held", 32'(cwp), 32'd2);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule